// File: doc/BRIEF.md
# Control-Register Bus Responder

This block is the target end of a narrow control-register bus. A single 16-bit input bus carries both register addresses and register values. Four strobes tell the responder what to do with it: take the bus value as the current address, take it as pending write data, commit the pending data to the addressed register, or return the addressed register's content. The responder keeps an address latch, a pending-data latch and a small register array that sits at a parameterised window of the address space. It answers every operation with a level acknowledge.

Each operation is a four-phase exchange. The master raises one strobe. After a parameterised number of clock cycles the responder performs the operation and raises the acknowledge. The master drops the strobe, and the responder drops the acknowledge on the next clock edge. The block stands in for a physical-layer register space, so a bus master can be verified end to end against real handshake timing. It models storage only.

Top module: `crr_responder`

## Requirements
- R1: While reset is low at a clock edge, the acknowledge, the read-data output, both latches and every register are cleared to zero; a register read after reset returns zero.
- R2: An accepted address strobe stores the input bus value as the current address. Later write and read operations use that address.
- R3: An accepted data strobe stores the input bus value as pending write data and leaves every register unchanged.
- R4: An accepted write strobe copies the pending data into the register at the current address. The input bus value present with the write strobe is not used.
- R5: An accepted read strobe drives the content of the register at the current address onto the read-data output. The output holds that value, unchanged, for as long as the acknowledge stays high.
- R6: A strobe is accepted at the first clock edge that samples it high while the responder is idle. The acknowledge rises exactly ACK_DELAY clock edges after that edge, and the operation takes effect at the same edge.
- R7: Once high, the acknowledge stays high while any strobe is high. It falls at the first clock edge that samples all four strobes low.
- R8: A strobe raised while the acknowledge is high causes no operation, even if it is still high when the first strobe is removed.
- R9: A write to an address outside the window BASE_ADDR to BASE_ADDR+NUM_REGS-1 is acknowledged with normal timing and changes no register.
- R10: A read from an address outside the window is acknowledged with normal timing and returns zero.
- R11: When several strobes are first seen together, only one operation is performed, chosen by the priority address > data > write > read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_din | input | 16 | Shared address / data input bus |
| strb_addr | input | 1 | Take bus_din as the current address |
| strb_data | input | 1 | Take bus_din as pending write data |
| strb_write | input | 1 | Commit pending data to the addressed register |
| strb_read | input | 1 | Return the addressed register on bus_dout |
| bus_dout | output | 16 | Read data, valid while bus_ack is high after a read |
| bus_ack | output | 1 | Level acknowledge |

## Verification
The bench builds the responder with ACK_DELAY set to 3, NUM_REGS set to 8 and BASE_ADDR set to 0x1000. With a delay of 3, every exchange passes through several cycles in which the acknowledge must still be low, so a responder that answers early or late shows up. With eight registers, every register in the window can be written and read back, including the last one. It also puts the addresses one below and one above the window within reach. The non-zero base makes the window lower bound checkable, and it catches decode that ignores the base.

// File: rtl/crr_pkg.sv
// Package: shared types for the control-register bus responder.
// Assumes strobe request vectors are ordered {read, write, data, address},
// so a request bit index equals the operation code.
package crr_pkg;

    // Operation codes; the value is also the arbitration rank (0 = highest).
    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_DATA  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } crr_op_e;

    localparam int unsigned NUM_OPS = 4;

endpackage

// File: rtl/crr_strobe_arb.sv
// Module: fixed-priority selector over the four strobes.
// What it does: reports whether any strobe is high and which single operation
// wins. Lower request index wins.
// Assumes: purely combinational; the caller decides when the result is used.
module crr_strobe_arb
    import crr_pkg::*;
#(
    parameter int unsigned N_REQ = NUM_OPS
) (
    input  logic [N_REQ-1:0] req,
    output logic             any_req,
    output logic [N_REQ-1:0] grant,
    output crr_op_e          op
);

    // One grant bit per request: granted when no lower index is asking.
    genvar gi;
    generate
        for (gi = 0; gi < int'(N_REQ); gi++) begin : g_grant
            if (gi == 0) begin : g_first
                assign grant[gi] = req[gi];
            end else begin : g_rest
                assign grant[gi] = req[gi] && !(|req[gi-1:0]);
            end
        end
    endgenerate

    assign any_req = |req;

    // Encode the one-hot grant into an operation code.
    always_comb begin
        op = OP_ADDR;
        for (int i = int'(N_REQ) - 1; i >= 0; i--) begin
            if (grant[i]) begin
                op = crr_op_e'(2'(i));
            end
        end
    end

endmodule

// File: rtl/crr_handshake.sv
// Module: four-phase handshake sequencer.
// What it does: accepts a strobe while idle, captures the winning operation
// and the bus value, waits ACK_DELAY edges, issues a one-cycle execute pulse
// together with raising ack, then holds ack until all strobes are low.
// Assumes: strobes are synchronous to clk; ACK_DELAY >= 1.
module crr_handshake
    import crr_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ACK_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_stb,
    input  crr_op_e           op_in,
    input  logic [DATA_W-1:0] din,
    output logic              exec,
    output crr_op_e           exec_op,
    output logic [DATA_W-1:0] exec_val,
    output logic              ack
);

    localparam int unsigned CNT_W = (ACK_DELAY < 2) ? 1 : $clog2(ACK_DELAY + 1);

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_e;

    hs_state_e         state_q;
    logic [CNT_W-1:0]  cnt_q;
    crr_op_e           op_q;
    logic [DATA_W-1:0] val_q;

    // Execute pulse: last wait cycle, when the delay counter has run out.
    assign exec     = (state_q == HS_WAIT) && (cnt_q == '0);
    assign exec_op  = op_q;
    assign exec_val = val_q;

    // Sequencer state, delay counter, captured request and ack level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            cnt_q   <= '0;
            op_q    <= OP_ADDR;
            val_q   <= '0;
            ack     <= 1'b0;
        end else begin
            case (state_q)
                HS_IDLE: begin
                    if (any_stb) begin
                        state_q <= HS_WAIT;
                        cnt_q   <= CNT_W'(ACK_DELAY - 1);
                        op_q    <= op_in;
                        val_q   <= din;
                    end
                end
                HS_WAIT: begin
                    if (cnt_q == '0) begin
                        state_q <= HS_HOLD;
                        ack     <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                HS_HOLD: begin
                    if (!any_stb) begin
                        state_q <= HS_IDLE;
                        ack     <= 1'b0;
                    end
                end
                default: begin
                    state_q <= HS_IDLE;
                    ack     <= 1'b0;
                end
            endcase
        end
    end

    // R7: ack never drops while a strobe is still high.
    assert_ack_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && any_stb) |=> ack);

    // R7: a falling ack always follows an edge that saw every strobe low.
    assert_ack_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack) |-> !$past(any_stb));

    // R8: no operation executes while ack is already high.
    assert_no_exec_in_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !exec);

endmodule

// File: rtl/crr_regfile.sv
// Module: register space behind the responder.
// What it does: holds the address latch, the pending-data latch, the register
// array decoded over [BASE_ADDR, BASE_ADDR+NUM_REGS) and the read-data output.
// Assumes: exec is a single-cycle pulse with a stable exec_op/exec_val.
module crr_regfile
    import crr_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_REGS  = 16,
    parameter int unsigned BASE_ADDR = 32'h0000_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exec,
    input  crr_op_e           exec_op,
    input  logic [DATA_W-1:0] exec_val,
    output logic [DATA_W-1:0] rd_out
);

    localparam int unsigned IDX_W = (NUM_REGS < 2) ? 1 : $clog2(NUM_REGS);

    logic [DATA_W-1:0]                addr_q;
    logic [DATA_W-1:0]                data_q;
    logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q;
    logic [31:0]                      offset;
    logic                             in_win;
    logic [IDX_W-1:0]                 idx;
    logic [NUM_REGS-1:0]              wr_sel;
    logic [DATA_W-1:0]                rd_mux;

    // Window decode: offset from the base, in range when below NUM_REGS.
    always_comb begin
        offset = 32'(addr_q) - BASE_ADDR;
        in_win = (32'(addr_q) >= BASE_ADDR) && (offset < NUM_REGS);
        idx    = offset[IDX_W-1:0];
    end

    // Per-register write enable.
    genvar gr;
    generate
        for (gr = 0; gr < int'(NUM_REGS); gr++) begin : g_wsel
            assign wr_sel[gr] = exec && (exec_op == OP_WRITE) && in_win
                                && (idx == IDX_W'(gr));
        end
    endgenerate

    // Read mux: the addressed register inside the window, zero outside.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < int'(NUM_REGS); i++) begin
            if (in_win && (idx == IDX_W'(i))) begin
                rd_mux = regs_q[i];
            end
        end
    end

    // Address and pending-data latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (exec) begin
            if (exec_op == OP_ADDR) addr_q <= exec_val;
            if (exec_op == OP_DATA) data_q <= exec_val;
        end
    end

    // Register array commit from the pending-data latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < int'(NUM_REGS); i++) begin
                if (wr_sel[i]) regs_q[i] <= data_q;
            end
        end
    end

    // Read-data output register, loaded on a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_out <= '0;
        end else if (exec && (exec_op == OP_READ)) begin
            rd_out <= rd_mux;
        end
    end

    // R3: capturing pending data leaves the register array untouched.
    assert_data_no_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && exec_op == OP_DATA) |=> $stable(regs_q));

    // R9: a write outside the window leaves the register array untouched.
    assert_oow_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && exec_op == OP_WRITE && !in_win) |=> $stable(regs_q));

    // R10: a read outside the window returns zero.
    assert_oow_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && exec_op == OP_READ && !in_win) |=> (rd_out == '0));

    // R4: a write in the window lands the pending data in the array.
    assert_write_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && exec_op == OP_WRITE && in_win) |=> (regs_q[$past(idx)] == $past(data_q)));

endmodule

// File: rtl/crr_responder.sv
// Module: top of the control-register bus responder.
// What it does: arbitrates the four strobes, runs the four-phase handshake and
// drives the register space; bus_dout and bus_ack are registered outputs.
// Assumes: all inputs synchronous to clk; ACK_DELAY >= 1; reset is
// synchronous and active low.
module crr_responder
    import crr_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_REGS  = 16,
    parameter int unsigned BASE_ADDR = 32'h0000_1000,
    parameter int unsigned ACK_DELAY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_din,
    input  logic              strb_addr,
    input  logic              strb_data,
    input  logic              strb_write,
    input  logic              strb_read,
    output logic [15:0]       bus_dout,
    output logic              bus_ack
);

    logic [NUM_OPS-1:0] req;
    logic [NUM_OPS-1:0] grant;
    logic               any_req;
    crr_op_e            arb_op;
    logic               exec;
    crr_op_e            exec_op;
    logic [DATA_W-1:0]  exec_val;
    logic [DATA_W-1:0]  rd_out;
    logic [DATA_W-1:0]  din_w;

    // Request vector in rank order: index equals the operation code.
    assign req   = {strb_read, strb_write, strb_data, strb_addr};
    assign din_w = DATA_W'(bus_din);

    crr_strobe_arb #(
        .N_REQ (NUM_OPS)
    ) u_arb (
        .req     (req),
        .any_req (any_req),
        .grant   (grant),
        .op      (arb_op)
    );

    crr_handshake #(
        .DATA_W    (DATA_W),
        .ACK_DELAY (ACK_DELAY)
    ) u_hs (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_stb  (any_req),
        .op_in    (arb_op),
        .din      (din_w),
        .exec     (exec),
        .exec_op  (exec_op),
        .exec_val (exec_val),
        .ack      (bus_ack)
    );

    crr_regfile #(
        .DATA_W    (DATA_W),
        .NUM_REGS  (NUM_REGS),
        .BASE_ADDR (BASE_ADDR)
    ) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .exec     (exec),
        .exec_op  (exec_op),
        .exec_val (exec_val),
        .rd_out   (rd_out)
    );

    assign bus_dout = 16'(rd_out);

    // R1: an edge with reset low leaves ack and read data at zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (bus_ack == 1'b0 && bus_dout == '0));

    // R5: read data stays put for the whole time ack is high.
    assert_dout_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && $past(bus_ack)) |-> $stable(bus_dout));

    // R11: at most one strobe wins arbitration.
    assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

endmodule

// File: tb/sim_crr_responder.sv
// Bench: directed scenarios, one task each, checking the responder at its ports.
module sim_crr_responder;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned ACKD  = 3;
    localparam int unsigned NREG  = 8;
    localparam int unsigned BASE  = 32'h0000_1000;

    localparam logic [3:0] M_ADDR  = 4'b0001;
    localparam logic [3:0] M_DATA  = 4'b0010;
    localparam logic [3:0] M_WRITE = 4'b0100;
    localparam logic [3:0] M_READ  = 4'b1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_din = '0;
    logic        strb_addr = 1'b0;
    logic        strb_data = 1'b0;
    logic        strb_write = 1'b0;
    logic        strb_read = 1'b0;
    logic [15:0] bus_dout;
    logic        bus_ack;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    logic [15:0] model [NREG];

    always #4 clk = ~clk;

    crr_responder #(
        .DATA_W    (16),
        .NUM_REGS  (NREG),
        .BASE_ADDR (BASE),
        .ACK_DELAY (ACKD)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_din    (bus_din),
        .strb_addr  (strb_addr),
        .strb_data  (strb_data),
        .strb_write (strb_write),
        .strb_read  (strb_read),
        .bus_dout   (bus_dout),
        .bus_ack    (bus_ack)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_strobes(input logic [3:0] m);
        strb_addr  = m[0];
        strb_data  = m[1];
        strb_write = m[2];
        strb_read  = m[3];
    endtask

    // One four-phase exchange; checks ack latency (R6), hold (R7), dout (R5).
    task automatic bus_op(input logic [3:0] m, input logic [15:0] v,
                          input int extra, output logic [15:0] rd);
        bit early = 1'b0;
        @(negedge clk);
        bus_din = v;
        set_strobes(m);
        for (int k = 1; k <= int'(ACKD); k++) begin
            @(negedge clk);
            if (bus_ack) early = 1'b1;
        end
        check(!early, "R6 ack early", 16'(early), 16'h0);
        @(negedge clk);
        check(bus_ack === 1'b1, "R6 ack rise", 16'(bus_ack), 16'h1);
        rd = bus_dout;
        for (int k = 0; k < extra; k++) begin
            @(negedge clk);
            check(bus_ack === 1'b1, "R7 ack held", 16'(bus_ack), 16'h1);
            check(bus_dout === rd, "R5 dout stable", bus_dout, rd);
        end
        set_strobes(4'b0000);
        bus_din = 16'hFFFF;
        @(negedge clk);
        check(bus_ack === 1'b0, "R7 ack fall", 16'(bus_ack), 16'h0);
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [15:0] v);
        logic [15:0] dummy;
        bus_op(M_ADDR, a, 0, dummy);
        bus_op(M_DATA, v, 0, dummy);
        bus_op(M_WRITE, 16'hA5A5, 0, dummy);
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [15:0] v);
        logic [15:0] dummy;
        bus_op(M_ADDR, a, 0, dummy);
        bus_op(M_READ, 16'h0000, 2, v);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check(bus_ack === 1'b0, "R1 ack after reset", 16'(bus_ack), 16'h0);
        check(bus_dout === 16'h0, "R1 dout after reset", bus_dout, 16'h0);
        rd_reg(16'(BASE + 5), v);
        check(v === 16'h0, "R1 register after reset", v, 16'h0);
    endtask

    task automatic t_write_read_all;
        logic [15:0] v;
        for (int i = 0; i < int'(NREG); i++) begin
            model[i] = 16'(16'h1357 * (i + 1)) ^ 16'hC3A0;
            wr_reg(16'(BASE + i), model[i]);
        end
        for (int i = int'(NREG) - 1; i >= 0; i--) begin
            rd_reg(16'(BASE + i), v);
            check(v === model[i], "R2 R4 write/read", v, model[i]);
        end
    endtask

    task automatic t_data_no_commit;
        logic [15:0] v;
        logic [15:0] dummy;
        bus_op(M_ADDR, 16'(BASE + 3), 0, dummy);
        bus_op(M_DATA, 16'h0BAD, 0, dummy);
        bus_op(M_READ, 16'h0000, 1, v);
        check(v === model[3], "R3 data capture changed register", v, model[3]);
    endtask

    task automatic t_out_of_window;
        logic [15:0] v;
        wr_reg(16'(BASE + NREG), 16'hDEAD);
        wr_reg(16'(BASE - 1), 16'hBEEF);
        rd_reg(16'(BASE + 2), v);
        check(v === model[2], "R5 read before oow", v, model[2]);
        rd_reg(16'(BASE + NREG), v);
        check(v === 16'h0, "R10 read above window", v, 16'h0);
        rd_reg(16'(BASE - 1), v);
        check(v === 16'h0, "R10 read below window", v, 16'h0);
        for (int i = 0; i < int'(NREG); i++) begin
            rd_reg(16'(BASE + i), v);
            check(v === model[i], "R9 window unchanged", v, model[i]);
        end
    endtask

    task automatic t_ignore_during_ack;
        logic [15:0] v;
        logic [15:0] dummy;
        wr_reg(16'(BASE + 1), 16'h1111);
        model[1] = 16'h1111;
        bus_op(M_DATA, 16'hBEEF, 0, dummy);
        @(negedge clk);
        bus_din = 16'(BASE + 1);
        set_strobes(M_ADDR);
        for (int k = 0; k <= int'(ACKD); k++) @(negedge clk);
        check(bus_ack === 1'b1, "R6 ack up", 16'(bus_ack), 16'h1);
        strb_write = 1'b1;
        @(negedge clk);
        strb_addr = 1'b0;
        @(negedge clk);
        check(bus_ack === 1'b1, "R7 ack held by late strobe", 16'(bus_ack), 16'h1);
        @(negedge clk);
        check(bus_ack === 1'b1, "R7 ack still held", 16'(bus_ack), 16'h1);
        strb_write = 1'b0;
        @(negedge clk);
        check(bus_ack === 1'b0, "R7 ack fall after all low", 16'(bus_ack), 16'h0);
        bus_op(M_READ, 16'h0000, 0, v);
        check(v === 16'h1111, "R8 late write ignored", v, 16'h1111);
    endtask

    task automatic t_priority;
        logic [15:0] v;
        logic [15:0] dummy;
        wr_reg(16'(BASE + 2), 16'h2222);
        model[2] = 16'h2222;
        bus_op(M_ADDR, 16'(BASE + 4), 0, dummy);
        bus_op(M_DATA, 16'h7777, 0, dummy);
        bus_op(M_ADDR | M_WRITE, 16'(BASE + 2), 0, dummy);
        bus_op(M_READ, 16'h0000, 0, v);
        check(v === 16'h2222, "R11 address beats write", v, 16'h2222);
        bus_op(M_DATA | M_READ, 16'h5A5A, 0, v);
        check(v === 16'h2222, "R11 data beats read", v, 16'h2222);
        bus_op(M_WRITE | M_READ, 16'h0000, 0, v);
        check(v === 16'h2222, "R11 write beats read", v, 16'h2222);
        bus_op(M_READ, 16'h0000, 0, v);
        check(v === 16'h5A5A, "R4 commit after priority", v, 16'h5A5A);
        model[2] = 16'h5A5A;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual 0x0001 expected 0x0000 (run hung)");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read_all();
        t_data_no_commit();
        t_out_of_window();
        t_ignore_during_ack();
        t_priority();
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule